// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two N-bit unsigned operands over several clock cycles. It uses a single row of N one-bit adders and a 2N-bit working register. A load strobe captures the multiplicand into a holding register. The same strobe clears the upper half of the working register and places the multiplier in the lower half.

After the load, the block runs N add/shift cycles. In each one, the lowest bit of the working register selects either the multiplicand or zero. That value is added into the upper half, the carry is kept as a new top bit, and the whole register shifts right by one place. The lower half therefore holds the unused multiplier bits together with the finished low product bits.

When the last step completes, a done pulse marks a valid 2N-bit product. The product then stays unchanged until the next accepted load. A whole multiply takes one load cycle plus N add/shift cycles.

Top module: `seq_shift_mul`

## Requirements
- R1: While reset is active and right after it is released, `busy`, `done` and `product` are all zero.
- R2: If `load` is high on a clock edge while `busy` is low, `busy` is high from the next cycle.
- R3: `done` goes high exactly N clock edges after the edge that accepted the load. In that same cycle `busy` returns low.
- R4: `done` is high for one cycle only.
- R5: When `done` is high, `product` equals the full 2N-bit unsigned product of the operands captured at the load. For example, with operands 11 and 13 the product is 143.
- R6: While `busy` is low and no load is accepted, `product` holds its value.
- R7: A `load` pulse that arrives while `busy` is high has no effect. The running multiply finishes on its original schedule with its original operands.
- R8: Changes on the operand inputs after the accepting edge do not affect the result.
- R9: The carry out of each addition is kept. With both operands all ones, the result is (2^N-1)^2, and zero times any operand is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Starts a multiply when idle |
| multiplicand | input | N | First operand, captured at load |
| multiplier | input | N | Second operand, captured at load |
| busy | output | 1 | High during the add/shift cycles |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2N | Working register and final product |

## Verification
The step counter, the captured multiplicand and the working register are all internal state. A wrong step count makes `done` arrive early or late relative to the load edge, and the bench measures that to the exact cycle. A lost carry or a wrong shift corrupts the high bits of the result, which all-ones operands expose at once. A busy-time load that leaks into the holding register yields a wrong product at the very next done pulse.

// File: rtl/seq_shift_mul.sv
module seq_shift_mul #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [N-1:0]   multiplicand,
  input  logic [N-1:0]   multiplier,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [N-1:0]  mcand_q;
  logic [CW-1:0] step_q;
  logic [N:0]    sum;
  logic          start;

  assign start = load && !busy;
  assign sum   = {1'b0, product[2*N-1:N]} + {1'b0, (product[0] ? mcand_q : '0)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      product <= '0;
      mcand_q <= '0;
      step_q  <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        product <= {{N{1'b0}}, multiplier};
        mcand_q <= multiplicand;
        step_q  <= '0;
        busy    <= 1'b1;
      end else if (busy) begin
        product <= {sum, product[N-1:1]};
        step_q  <= step_q + 1'b1;
        if (step_q == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assert_busy_after_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !busy) |=> busy);

  assert_done_ends_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_step_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step_q < CW'(N)));

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load) |=> $stable(product));

  assert_busy_load_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load) |=> $stable(mcand_q));
endmodule

// File: tb/seq_shift_mul_bench.sv
module seq_shift_mul_bench;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           load = 1'b0;
  logic [N-1:0]   mcand = '0;
  logic [N-1:0]   mplier = '0;
  logic           busy, done;
  logic [2*N-1:0] product;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  seq_shift_mul #(.N(N)) u_seq_shift_mul (
    .clk(clk), .rst_n(rst_n), .load(load),
    .multiplicand(mcand), .multiplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  always #10 clk = ~clk;

  function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [2*N-1:0] wa;
    logic [2*N-1:0] wb;
    wa = {{N{1'b0}}, a};
    wb = {{N{1'b0}}, b};
    return wa * wb;
  endfunction

  task automatic check(input string req, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [N-1:0] a, input logic [N-1:0] b, input bit mid_load);
    logic [2*N-1:0] exp;
    logic [2*N-1:0] held;
    int cyc;
    exp = ref_mul(a, b);
    @(negedge clk);
    load = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    load = 1'b0;
    cyc = 0;
    check("R2 busy after load", {{(2*N-1){1'b0}}, busy}, 1);
    mcand = N'($urandom); mplier = N'($urandom);  // R8
    if (mid_load) begin
      load = 1'b1;                                 // R7
      @(negedge clk);
      cyc++;
      load = 1'b0;
    end
    while (!done && cyc < N + 4) begin
      @(negedge clk);
      cyc++;
    end
    check("R3 done latency", 2*N'(cyc), 2*N'(N));
    check("R3 busy low at done", {{(2*N-1){1'b0}}, busy}, 0);
    check(mid_load ? "R7 R5 product" : "R5 R8 R9 product", product, exp);
    held = product;
    @(negedge clk);
    check("R4 done single cycle", {{(2*N-1){1'b0}}, done}, 0);
    repeat (2) @(negedge clk);
    check("R6 product held", product, held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset product", product, 0);
    check("R1 reset flags", {{(2*N-2){1'b0}}, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {{(2*N-2){1'b0}}, busy, done}, 0);
    check("R1 product after release", product, 0);
    void'($urandom(32'd1234));
    run(N'(11), N'(13), 0);
    run('1, '1, 0);
    run('0, '1, 0);
    run('1, '0, 0);
    run(N'(1), '1, 0);
    run(N'(8'h80), N'(8'h80), 1);
    for (int i = 0; i < 40; i++) run(N'($urandom), N'($urandom), (i % 3) == 0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule